// File: doc/BRIEF.md
# Normal-Basis Binary Field Arithmetic Processor

This block is the datapath core of a binary-field elliptic-curve engine. Each field element is an m-bit vector in normal-basis form. Elements live in a directly addressed register file of 2^AW words, and the file has two independent read ports. A sequencer outside the block issues one instruction per cycle. Each instruction carries a source address, a destination address, an operation code and a 6-bit repeat count.

The block executes these instructions itself:
- addition (XOR);
- repeated squaring, which in normal basis reduces to a single cyclic rotation;
- loading a word from the data input;
- storing a word to the data output.

Multiplication goes to an external multiplier through a start/done handshake. While a product is outstanding the block holds a busy flag and ignores new instructions. When done arrives, it writes the product back to the saved destination address.

Bit i of a stored word is the coefficient of the basis element β^(2^i). Squaring moves coefficient i to position i+1, so k squarings rotate the vector k places toward the most significant bit.

Top module: `nb_field_proc`

## Requirements
- R1: After reset, `busy`, `out_valid` and `mul_start` are 0.
- R2: Opcode 1 (ADD) writes word[A] XOR word[B] into word[B]. When A equals B, the result is zero.
- R3: Opcode 2 (SQR) writes word[A] rotated by (`shamt` mod M) positions into word[B], where result bit i equals source bit (i − k) mod M. A count of 0 copies the word, and A may equal B.
- R4: Opcode 4 (LOAD) writes `data_in` into word[B].
- R5: Opcode 5 (STORE) puts word[A] on `data_out` with `out_valid` high for exactly the one cycle after the issue edge. Every other operation leaves `out_valid` low.
- R6: Opcode 3 (MUL) raises `mul_start` for exactly one cycle after the issue edge, presents word[A] on `mul_a` and word[B] on `mul_b`, and sets `busy`.
- R7: While `busy` is high, a `mul_done` pulse writes `mul_result` into the destination word of the multiply, and `busy` falls on that same edge. Without `mul_done`, `busy` stays high.
- R8: An instruction issued while `busy` is high has no effect: no write, no new `mul_start`, no store output.
- R9: Opcodes 0 and 6 to 15 change no word and produce no output.
- R10: Each operation reads its operands before any write on the same edge. Results are visible to the very next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction valid this cycle |
| addr_a | input | AW | Source operand address |
| addr_b | input | AW | Second operand and destination address |
| opcode | input | 4 | Operation code |
| shamt | input | 6 | Squaring repeat count |
| data_in | input | M | Word for LOAD |
| data_out | output | M | Word from STORE |
| out_valid | output | 1 | `data_out` valid |
| busy | output | 1 | Multiply outstanding |
| mul_start | output | 1 | Multiplier start pulse |
| mul_a | output | M | Multiplier operand 1 |
| mul_b | output | M | Multiplier operand 2 |
| mul_done | input | 1 | Multiplier result valid |
| mul_result | input | M | Multiplier product |

## Verification
ADD, SQR and LOAD results land in the register file on the issue edge. The bench reads them back with a STORE, whose output is registered and is valid at the falling edge after the STORE's issue edge. The bench samples `mul_start`, `mul_a`, `mul_b` and `busy` at the falling edge one cycle after a MUL is issued, and checks that `mul_start` has cleared one cycle later. The multiplier model asserts `mul_done` at a falling edge, and `busy` is sampled low at the next falling edge. All checks happen on falling edges, so every sample is taken half a period after the register that produces it has updated.

// File: rtl/nb_field_proc.sv
module nb_field_proc #(
  parameter int M     = 163,
  parameter int AW    = 9,
  parameter int SHW   = 6,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic [3:0]    opcode,
  input  logic [SHW-1:0] shamt,
  input  logic [M-1:0]  data_in,
  output logic [M-1:0]  data_out,
  output logic          out_valid,
  output logic          busy,
  output logic          mul_start,
  output logic [M-1:0]  mul_a,
  output logic [M-1:0]  mul_b,
  input  logic          mul_done,
  input  logic [M-1:0]  mul_result
);
  localparam logic [3:0] OP_ADD = 4'd1;
  localparam logic [3:0] OP_SQR = 4'd2;
  localparam logic [3:0] OP_MUL = 4'd3;
  localparam logic [3:0] OP_LD  = 4'd4;
  localparam logic [3:0] OP_ST  = 4'd5;

  logic [M-1:0]  regs [DEPTH];
  logic [M-1:0]  rd_a, rd_b, sq, wr_data;
  logic [AW-1:0] wr_addr, dst_q;
  logic          wr_en, accept;
  int            rot_k;

  assign rd_a   = regs[addr_a];
  assign rd_b   = regs[addr_b];
  assign accept = issue & ~busy;

  always_comb begin
    rot_k = int'(shamt) % M;
    for (int i = 0; i < M; i++) sq[i] = rd_a[(i + M - rot_k) % M];
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = addr_b;
    wr_data = '0;
    if (busy && mul_done) begin
      wr_en   = 1'b1;
      wr_addr = dst_q;
      wr_data = mul_result;
    end else if (accept) begin
      case (opcode)
        OP_ADD:  begin wr_en = 1'b1; wr_data = rd_a ^ rd_b; end
        OP_SQR:  begin wr_en = 1'b1; wr_data = sq;          end
        OP_LD:   begin wr_en = 1'b1; wr_data = data_in;     end
        default: wr_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) regs[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      mul_start <= 1'b0;
      out_valid <= 1'b0;
      data_out  <= '0;
      mul_a     <= '0;
      mul_b     <= '0;
      dst_q     <= '0;
    end else begin
      mul_start <= 1'b0;
      out_valid <= 1'b0;
      if (busy && mul_done) busy <= 1'b0;
      if (accept && opcode == OP_ST) begin
        out_valid <= 1'b1;
        data_out  <= rd_a;
      end
      if (accept && opcode == OP_MUL) begin
        busy      <= 1'b1;
        mul_start <= 1'b1;
        mul_a     <= rd_a;
        mul_b     <= rd_b;
        dst_q     <= addr_b;
      end
    end
  end
endmodule

// File: rtl/nb_field_proc_chk.sv
module nb_field_proc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       issue,
  input logic [3:0] opcode,
  input logic       busy,
  input logic       mul_start,
  input logic       mul_done,
  input logic       out_valid
);
  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mul_start |=> !mul_start);
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mul_start |-> busy);
  p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mul_start |-> !$past(busy));
  p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mul_done) |=> !busy);
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mul_done) |=> busy);
  p_store_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !busy && opcode == 4'd5) |=> out_valid);
  p_valid_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(issue && !busy && opcode == 4'd5));
endmodule

bind nb_field_proc nb_field_proc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode), .busy(busy),
  .mul_start(mul_start), .mul_done(mul_done), .out_valid(out_valid)
);

// File: tb/test_nb_field_proc.sv
module test_nb_field_proc;
  localparam int M = 11;
  localparam int AW = 9;
  localparam int CLK_PERIOD = 10;
  localparam logic [M-1:0] MASK = '1;

  logic clk = 0, rst_n = 0, issue = 0, mul_done = 0;
  logic [AW-1:0] addr_a = '0, addr_b = '0;
  logic [3:0] opcode = '0;
  logic [5:0] shamt = '0;
  logic [M-1:0] data_in = '0, mul_result = '0;
  logic [M-1:0] data_out, mul_a, mul_b;
  logic out_valid, busy, mul_start;

  int n_chk = 0, n_fail = 0;
  logic [M-1:0] model [1 << AW];

  always #(CLK_PERIOD/2) clk = ~clk;

  nb_field_proc #(.M(M), .AW(AW)) i_nb_field_proc (
    .clk(clk), .rst_n(rst_n), .issue(issue), .addr_a(addr_a), .addr_b(addr_b),
    .opcode(opcode), .shamt(shamt), .data_in(data_in), .data_out(data_out),
    .out_valid(out_valid), .busy(busy), .mul_start(mul_start), .mul_a(mul_a),
    .mul_b(mul_b), .mul_done(mul_done), .mul_result(mul_result));

  function automatic logic [M-1:0] rotl(logic [M-1:0] v, int k);
    logic [2*M-1:0] d;
    d = {v, v} << (k % M);
    return d[2*M-1:M];
  endfunction

  task automatic chk(string req, logic [M-1:0] act, logic [M-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(logic [3:0] o, int a, int b, int sh, logic [M-1:0] d);
    @(negedge clk);
    issue = 1; opcode = o; addr_a = AW'(a); addr_b = AW'(b);
    shamt = 6'(sh); data_in = d;
    @(negedge clk);
    issue = 0;
  endtask

  task automatic store_chk(string req, int a);
    op(4'd5, a, 0, 0, '0);
    chk({req, " out_valid"}, M'(out_valid), M'(1));
    chk(req, data_out, model[a]);
    @(negedge clk);
    chk({req, " R5 pulse"}, M'(out_valid), M'(0));
  endtask

  task automatic do_mul(int a, int b, logic [M-1:0] res);
    op(4'd3, a, b, 0, '0);
    chk("R6 mul_start", M'(mul_start), M'(1));
    chk("R6 busy", M'(busy), M'(1));
    chk("R6 mul_a", mul_a, model[a]);
    chk("R6 mul_b", mul_b, model[b]);
    @(negedge clk);
    chk("R6 start one cycle", M'(mul_start), M'(0));
    op(4'd4, 0, 30, 0, ~model[30]);
    op(4'd3, 1, 31, 0, '0);
    chk("R8 no restart", M'(mul_start), M'(0));
    op(4'd5, 2, 0, 0, '0);
    chk("R8 no store", M'(out_valid), M'(0));
    chk("R7 busy hold", M'(busy), M'(1));
    mul_done = 1; mul_result = res;
    @(negedge clk);
    mul_done = 0;
    chk("R7 busy clear", M'(busy), M'(0));
    model[b] = res;
    store_chk("R7 writeback", b);
    store_chk("R8 load ignored", 30);
    store_chk("R8 mul ignored", 31);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", M'(busy), M'(0));
    chk("R1 out_valid", M'(out_valid), M'(0));
    chk("R1 mul_start", M'(mul_start), M'(0));
    rst_n = 1;

    for (int i = 0; i < 40; i++) begin
      model[i] = M'((i * 173 + 91) ^ (i << 6)) & MASK;
      op(4'd4, 0, i, 0, model[i]);
    end
    model[511] = M'(11'h5a3);
    op(4'd4, 0, 511, 0, model[511]);
    for (int i = 0; i < 16; i++) store_chk("R4 load", i);
    store_chk("R4 load top", 511);

    for (int i = 0; i < 8; i++)
      for (int j = 8; j < 16; j++) begin
        op(4'd1, i, j, 0, '0);
        model[j] = model[i] ^ model[j];
        store_chk("R2 add", j);
      end
    op(4'd1, 511, 3, 0, '0);
    model[3] = model[511] ^ model[3];
    store_chk("R2 add top", 3);
    op(4'd1, 4, 4, 0, '0);
    model[4] = '0;
    store_chk("R2 self add", 4);

    for (int s = 0; s < 64; s++) begin
      op(4'd2, 20, 21, s, '0);
      model[21] = rotl(model[20], s);
      store_chk("R3 rotate", 21);
    end
    for (int s = 1; s < 64; s += 7) begin
      op(4'd2, 22, 22, s, '0);
      model[22] = rotl(model[22], s);
      store_chk("R3 in place", 22);
    end

    op(4'd4, 0, 23, 0, 11'h123);
    op(4'd1, 23, 24, 0, '0);
    model[23] = 11'h123;
    model[24] = model[23] ^ model[24];
    store_chk("R10 back to back", 24);

    for (int o = 0; o < 16; o++) begin
      if (o >= 1 && o <= 5) continue;
      op(4'(o), 1, 2, 5, ~model[2]);
      chk("R9 no output", M'(out_valid), M'(0));
      store_chk("R9 undefined op", 2);
    end

    do_mul(5, 6, 11'h2b7);
    do_mul(7, 7, 11'h0f1);
    do_mul(511, 8, 11'h7ff);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule